// File: doc/BRIEF.md
# I2C Bit-Rate Strobe Generator

This block turns the system clock into the timing pulses that an I2C protocol engine needs. The clock is slowed in two steps. First it is divided by a power of two, 2^N. Then the result is divided again by (M+1). One SCL period is made of ten sub-phases, so the full period is 10 × 2^N × (M+1) system-clock cycles. Both factors come from one small configuration register. For example, an intermediate rate of 12 MHz gives 100 kHz with M = 11 and 400 kHz with M = 2.

The engine does not count cycles itself. It receives three one-cycle strobes:
- one where SCL should rise,
- one where SCL should fall,
- one where SDA should be sampled, inside the high half of the period.

A level output tells which half of the period is in progress. Driving the actual SCL pin and handling clock stretching stay in the protocol engine. Stretching is supported by dropping the `run` input, which freezes and clears the timing.

Top module: `i2c_rate_strobe_gen`

## Requirements
- R1: The configuration register loads on `cfg_we`. Bits [2:0] of `cfg_wdata` set the prescale exponent N. Bits [6:3] set the divide factor M. After reset both fields are zero.
- R2: While `run` stays high and no write occurs, `scl_rise_stb` pulses exactly once every 10 × 2^N × (M+1) cycles. The same period holds for `scl_fall_stb` and `sda_sample_stb`.
- R3: Let P = 2^N × (M+1), and count cycle k from the restart edge. Then `scl_rise_stb` is high after edge k when k/P ≡ 5 (mod 10). `sda_sample_stb` is high when k/P ≡ 7 (mod 10). `scl_fall_stb` is high when k/P ≡ 0 (mod 10) and k > 0. In every case k must be a multiple of P.
- R4: `scl_high_phase` is high exactly when floor(k/P) mod 10 is 5 or more. It is high when a rise strobe fires and low when a fall strobe fires.
- R5: Each strobe is one cycle wide. At most one of the three strobes is high in any cycle.
- R6: A write to the configuration register clears every counter and every strobe at that edge. The next period is timed from the write edge, so no shortened period is produced.
- R7: While `run` is low, all counters stay at zero, no strobe fires and `scl_high_phase` is low. When `run` rises, timing restarts from zero.
- R8: Under reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | Enables timing; low holds everything at zero |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 7 | Configuration value: M in [6:3], N in [2:0] |
| scl_rise_stb | output | 1 | One-cycle pulse at the SCL rising point |
| scl_fall_stb | output | 1 | One-cycle pulse at the SCL falling point |
| sda_sample_stb | output | 1 | One-cycle pulse at the SDA sample point in the high half |
| scl_high_phase | output | 1 | High during the high half of the SCL period |

## Verification
Every fault in the prescaler, the divider or the sub-phase counter shifts the strobe positions away from exact multiples of P. Such a fault shows up on the ports at the first expected strobe, within 10·P cycles of a restart. A clear that fails on a write or on a low `run` leaves the old count in place, so the first strobe comes early. This is caught in the first period after the event. A wrong phase decode shows as a strobe that disagrees with `scl_high_phase` in that same cycle.

// File: rtl/i2c_rate_pkg.sv
// Shared constants for the I2C bit-rate strobe generator.
// Assumes one SCL period is split into an even number of sub-phases.
package i2c_rate_pkg;
    localparam int RATE_N_W    = 3;   // width of the power-of-two exponent field
    localparam int RATE_M_W    = 4;   // width of the linear divide field
    localparam int RATE_PHASES = 10;  // sub-phases per SCL period

    // Cycles per SCL period for a given exponent and divide factor.
    function automatic int unsigned full_period(input int unsigned n, input int unsigned m);
        return RATE_PHASES * (32'd1 << n) * (m + 1);
    endfunction
endpackage

// File: rtl/pow2_prescaler.sv
// Power-of-two prescaler: pulses tick once every 2^sel cycles.
// Assumes clr restarts the count at zero and suppresses the tick in that cycle.
module pow2_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    // Terminal count is a mask of sel low ones.
    always_comb lim = ~({CNT_W{1'b1}} << sel);

    // Tick on the terminal count unless cleared.
    always_comb tick = !clr && (cnt == lim);

    // Free-running count that wraps on tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) cnt <= '0;
        else                       cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/range_divider.sv
// Linear divider: pulses tick on every (lim+1)-th step.
// Assumes step is a one-cycle enable from the prescaler.
module range_divider #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] lim,
    output logic         tick
);
    logic [W-1:0] cnt;

    // Last step of each group of lim+1 steps.
    always_comb tick = !clr && step && (cnt == lim);

    // Count steps, wrapping at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)   cnt <= '0;
        else if (tick)       cnt <= '0;
        else if (step)       cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/phase_sequencer.sv
// Walks the sub-phases of one SCL period and emits registered strobes.
// Sub-phases 0..PHASES/2-1 are low, the rest high. The sample point is the
// sub-phase boundary nearest the middle of the high half, on its early side.
module phase_sequencer #(
    parameter int PHASES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic rise_stb,
    output logic fall_stb,
    output logic sample_stb,
    output logic high_phase
);
    localparam int PH_W      = $clog2(PHASES);
    localparam int HALF      = PHASES / 2;
    localparam int RISE_AT   = HALF - 1;
    localparam int FALL_AT   = PHASES - 1;
    localparam int SAMPLE_AT = HALF + HALF / 2 - 1;

    logic [PH_W-1:0] sub;
    logic            adv;

    // A sub-phase advances only when not cleared.
    always_comb adv = step && !clr;

    // Sub-phase counter, wrapping after the last sub-phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            sub <= '0;
        else if (adv)
            sub <= (sub == PH_W'(FALL_AT)) ? '0 : sub + PH_W'(1);
    end

    // Strobes are registered so each lines up with the new sub-phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rise_stb   <= 1'b0;
            fall_stb   <= 1'b0;
            sample_stb <= 1'b0;
        end else begin
            rise_stb   <= adv && (sub == PH_W'(RISE_AT));
            fall_stb   <= adv && (sub == PH_W'(FALL_AT));
            sample_stb <= adv && (sub == PH_W'(SAMPLE_AT));
        end
    end

    // Level for the high half of the period.
    always_comb high_phase = (sub >= PH_W'(HALF));
endmodule

// File: rtl/i2c_rate_strobe_gen.sv
// Top of the I2C bit-rate strobe generator: configuration register, a
// 2^N prescaler, an (M+1) divider and a ten-step phase sequencer.
// Assumes a write or a low run restarts all timing from zero.
module i2c_rate_strobe_gen
    import i2c_rate_pkg::*;
#(
    parameter int N_W    = RATE_N_W,
    parameter int M_W    = RATE_M_W,
    parameter int PHASES = RATE_PHASES,
    localparam int CFG_W = N_W + M_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             scl_rise_stb,
    output logic             scl_fall_stb,
    output logic             sda_sample_stb,
    output logic             scl_high_phase
);
    logic [N_W-1:0] cfg_n_q;
    logic [M_W-1:0] cfg_m_q;
    logic           clr;
    logic           pre_tick;
    logic           div_tick;

    // Configuration register: M in the upper bits, N in the lower bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_n_q <= '0;
            cfg_m_q <= '0;
        end else if (cfg_we) begin
            cfg_n_q <= cfg_wdata[N_W-1:0];
            cfg_m_q <= cfg_wdata[CFG_W-1:N_W];
        end
    end

    // Any write or a stopped run clears all timing state.
    always_comb clr = cfg_we || !run;

    pow2_prescaler #(.SEL_W(N_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(clr), .sel(cfg_n_q), .tick(pre_tick)
    );

    range_divider #(.W(M_W)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step(pre_tick),
        .lim(cfg_m_q), .tick(div_tick)
    );

    phase_sequencer #(.PHASES(PHASES)) u_seq (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step(div_tick),
        .rise_stb(scl_rise_stb), .fall_stb(scl_fall_stb),
        .sample_stb(sda_sample_stb), .high_phase(scl_high_phase)
    );
endmodule

// File: rtl/i2c_rate_strobe_chk.sv
// Property checker for the I2C bit-rate strobe generator, bound to the top.
// Tracks the gap between rise strobes with a counter rather than a deep $past.
module i2c_rate_strobe_chk
    import i2c_rate_pkg::*;
#(
    parameter int N_W = RATE_N_W,
    parameter int M_W = RATE_M_W
) (
    input logic           clk,
    input logic           rst_n,
    input logic           run,
    input logic           cfg_we,
    input logic [N_W-1:0] cfg_n,
    input logic [M_W-1:0] cfg_m,
    input logic           rise,
    input logic           fall,
    input logic           sample,
    input logic           high
);
    logic [31:0] gap;
    logic        seen;

    // Cycles since the last rise strobe, forgotten on any restart.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_we || !run) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (rise) begin
            gap  <= 32'd1;
            seen <= 1'b1;
        end else begin
            gap  <= gap + 32'd1;
        end
    end

    p_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && seen) |-> (gap == full_period(32'(cfg_n), 32'(cfg_m))));

    p_rise_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> high);

    p_fall_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> !high);

    p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise, fall, sample}));

    p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    p_write_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !(rise || fall || sample || high));

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !(rise || fall || sample || high));
endmodule

bind i2c_rate_strobe_gen i2c_rate_strobe_chk #(.N_W(N_W), .M_W(M_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we),
    .cfg_n(cfg_n_q), .cfg_m(cfg_m_q),
    .rise(scl_rise_stb), .fall(scl_fall_stb),
    .sample(sda_sample_stb), .high(scl_high_phase)
);

// File: tb/i2c_rate_strobe_gen_bench.sv
`timescale 1ns/1ps
module i2c_rate_strobe_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic       cfg_we = 1'b0;
    logic [6:0] cfg_wdata = '0;
    logic       rise, fall, sample, high;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    i2c_rate_strobe_gen u_i2c_rate_strobe_gen (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .scl_rise_stb(rise), .scl_fall_stb(fall),
        .sda_sample_stb(sample), .scl_high_phase(high)
    );

    task automatic check(input string req, input string what, input int k,
                         input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s k=%0d got %b expected %b", req, what, k, got, exp);
        end
    endtask

    // R1: write N to bits [2:0] and M to bits [6:3].
    task automatic write_cfg(input int n, input int m);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = {4'(m), 3'(n)};
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Checks cycles 1..cycles after a restart edge against the arithmetic model.
    task automatic sweep(input int n, input int m, input int cycles, input string req);
        int p = (1 << n) * (m + 1);
        for (int k = 1; k <= cycles; k++) begin
            int  q = k / p;
            int  s = q % 10;
            logic at = (k % p) == 0;
            @(posedge clk);
            #1;
            check(req, "R3 rise",   k, rise,   at && s == 5);
            check(req, "R3 fall",   k, fall,   at && s == 0);
            check(req, "R3 sample", k, sample, at && s == 7);
            check(req, "R4 high",   k, high,   s >= 5);
        end
    endtask

    // R7: with run low, nothing moves.
    task automatic idle_check(input int cycles);
        for (int k = 1; k <= cycles; k++) begin
            @(posedge clk);
            #1;
            check("R7", "idle strobes", k, rise | fall | sample, 1'b0);
            check("R7", "idle high",    k, high, 1'b0);
        end
    endtask

    initial begin
        // R8: outputs low under reset.
        repeat (3) @(posedge clk);
        #1;
        check("R8", "reset strobes", 0, rise | fall | sample, 1'b0);
        check("R8", "reset high",    0, high, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        idle_check(6);

        // R1: reset config is N=0, M=0, so P=1.
        @(negedge clk);
        run = 1'b1;
        sweep(0, 0, 25, "R1");

        // R2 R3 R4 R6: sweep every M for small N, rewriting mid-period.
        for (int n = 0; n < 4; n++)
            for (int m = 0; m < 16; m++) begin
                write_cfg(n, m);
                sweep(n, m, 20 * (1 << n) * (m + 1) + 3, "R2");
            end

        // R1: largest exponent and factor.
        write_cfg(7, 15);
        sweep(7, 15, 10 * 128 * 16 + 2, "R1");

        // R6: a write while a period is in flight restarts the timing.
        write_cfg(1, 2);
        sweep(1, 2, 37, "R6");
        write_cfg(2, 1);
        sweep(2, 1, 90, "R6");

        // R7: stop mid-period, then resume from zero.
        @(negedge clk);
        run = 1'b0;
        idle_check(40);
        @(negedge clk);
        run = 1'b1;
        sweep(2, 1, 85, "R7");

        // R7: a write while stopped still loads, and takes effect on resume.
        @(negedge clk);
        run = 1'b0;
        write_cfg(0, 3);
        idle_check(5);
        @(negedge clk);
        run = 1'b1;
        sweep(0, 3, 45, "R7");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule